// File: doc/BRIEF.md
# Output Port Link Arbiter

This block is the last stage of a switch output port. Cells arrive from the crossbar tagged with one of two virtual channels, and outgoing flow-control messages arrive on their own input. All three streams are held in one storage array. The array is split into fixed regions: one for each data channel and one for the flow-control messages. Because the regions are fixed, a busy channel can never take space from the others.

In every cycle that the link can accept a word, a priority encoder picks the source of that word in the same cycle. A waiting flow-control message goes first, but only between packets. Channel 0 data comes next and channel 1 data last. A data channel takes part only while its downstream credit counter is above zero. Once the first cell of a packet has been sent, the arbiter stays on that channel until the packet's last cell has gone out. Cells are forwarded in cut-through fashion, so a packet can start on the link while its later cells are still arriving. If the packet's channel runs dry in the middle, the link stays idle; it does not switch to another channel.

Top module: `oport_arb`

## Requirements
- R1: After reset, `linkValid` is 0, `qFull` is 0, all three regions are empty and both downstream credit counters hold `CNT_INIT`.
- R2: Each region is a FIFO. A word picked at a rising edge appears on `linkValid`/`linkSrc`/`linkData`/`linkLast` for exactly the one cycle after that edge. A cell written at edge k can be on the link after edge k+1 (cut-through).
- R3: `linkSrc` encodes the source: 0 is channel 0 data, 1 is channel 1 data, 2 is a flow-control message. When no packet is in progress, a pending flow-control message is sent before any data. Flow-control messages always leave with `linkLast` = 1.
- R4: When no packet is in progress, an eligible channel 0 cell is sent before a channel 1 cell.
- R5: After a cell with last = 0 is sent, only that channel is served, until its last cell is sent. Waiting flow-control messages and other-channel data wait until then.
- R6: If the locked channel's region is empty in the middle of a packet, `linkValid` stays 0 until that channel's next cell arrives, even when other sources are waiting.
- R7: A data channel is eligible only while its credit counter is non-zero. Each cell sent on the channel decrements its counter by one. A channel with zero credit does not block the other channel.
- R8: A `retValid` pulse adds one credit to the channel `retVc`. A return and a send on the same channel in the same cycle leave the counter unchanged.
- R9: The regions hold `VC0_DEPTH`, `VC1_DEPTH` and `CRD_DEPTH` entries. `qFull[i]` is 1 while region i (in `linkSrc` encoding) is full. A write into a full region is dropped and has no effect on the other regions.
- R10: In a cycle whose closing edge sees `linkReady` = 0, nothing is picked, no region is popped and no credit is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cellValid | input | 1 | Cell write from the crossbar |
| cellVc | input | 1 | Channel of the written cell |
| cellData | input | DW | Cell payload |
| cellLast | input | 1 | Cell closes its packet |
| crdValid | input | 1 | Flow-control message write |
| crdData | input | DW | Flow-control message payload |
| retValid | input | 1 | One credit returned by the downstream receiver |
| retVc | input | 1 | Channel of the returned credit |
| linkReady | input | 1 | Link accepts a word at the next edge |
| linkValid | output | 1 | Link word valid this cycle |
| linkSrc | output | 2 | Source of the link word (0, 1 data channel; 2 flow-control) |
| linkData | output | DW | Link word payload |
| linkLast | output | 1 | Link word closes a packet |
| qFull | output | 3 | Region full flags, indexed like `linkSrc` |

## Verification
The hardest situation to reach is a stall in the middle of a packet while other sources are waiting. It needs a channel locked on a packet, an empty region for that channel, and both a competing channel and a flow-control message ready to go. The stimulus sends the first cell of a packet through the cut-through path and then withholds the rest. While the link is locked, it writes a channel 0 cell and a flow-control message, so the idle link and the order in which the waiting words leave afterwards can be checked edge by edge. Credit starvation is handled the same way. The bench starts with a small credit allowance, sends until a channel's credit is used up, and then returns credits one at a time.

// File: rtl/oport_pkg.sv
package oport_pkg;

  typedef enum logic [1:0] {
    SRC_VC0 = 2'd0,
    SRC_VC1 = 2'd1,
    SRC_CRD = 2'd2
  } src_e;

  // strobe bundle from the picker to the store
  typedef struct packed {
    logic send;
    src_e src;
  } pick_s;

endpackage

// File: rtl/oport_pick.sv
module oport_pick
  import oport_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int CNT_INIT = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] notEmpty,
  input  logic [1:0] headLast,
  input  logic       linkReady,
  input  logic       retValid,
  input  logic       retVc,
  output pick_s      pk
);

  logic [CNT_W-1:0] crd [2];
  logic [1:0]       elig;
  logic             locked;
  logic             lockVc;

  for (genvar v = 0; v < 2; v++) begin : g_vc
    logic inc;
    logic dec;
    assign elig[v] = notEmpty[v] && (crd[v] != '0);
    assign inc     = retValid && (retVc == 1'(v));
    assign dec     = pk.send && (pk.src == ((v == 0) ? SRC_VC0 : SRC_VC1));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        crd[v] <= CNT_W'(CNT_INIT);
      end else begin
        case ({inc, dec})
          2'b10:   crd[v] <= crd[v] + 1'b1;
          2'b01:   crd[v] <= crd[v] - 1'b1;
          default: crd[v] <= crd[v];
        endcase
      end
    end

    // R7: a cell may only leave on a channel holding credit
    a_r7_credit_gate: assert property (@(posedge clk) disable iff (!rstN)
      dec |-> (crd[v] != '0));
  end

  always_comb begin
    pk = '{send: 1'b0, src: SRC_VC0};
    if (linkReady) begin
      if (locked) begin
        if (elig[lockVc]) begin
          pk.send = 1'b1;
          pk.src  = lockVc ? SRC_VC1 : SRC_VC0;
        end
      end else if (notEmpty[2]) begin
        pk.send = 1'b1;
        pk.src  = SRC_CRD;
      end else if (elig[0]) begin
        pk.send = 1'b1;
        pk.src  = SRC_VC0;
      end else if (elig[1]) begin
        pk.send = 1'b1;
        pk.src  = SRC_VC1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      locked <= 1'b0;
      lockVc <= 1'b0;
    end else if (pk.send && (pk.src != SRC_CRD)) begin
      locked <= !headLast[pk.src[0]];
      lockVc <= pk.src[0];
    end
  end

endmodule

// File: rtl/oport_store.sv
module oport_store
  import oport_pkg::*;
#(
  parameter int DW        = 8,
  parameter int VC0_DEPTH = 4,
  parameter int VC1_DEPTH = 4,
  parameter int CRD_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cellValid,
  input  logic          cellVc,
  input  logic [DW-1:0] cellData,
  input  logic          cellLast,
  input  logic          crdValid,
  input  logic [DW-1:0] crdData,
  input  pick_s         pk,
  output logic [2:0]    notEmpty,
  output logic [1:0]    headLast,
  output logic [2:0]    qFull,
  output logic          linkValid,
  output logic [1:0]    linkSrc,
  output logic [DW-1:0] linkData,
  output logic          linkLast
);

  localparam int TOT  = VC0_DEPTH + VC1_DEPTH + CRD_DEPTH;
  localparam int MAXD = (VC0_DEPTH > VC1_DEPTH)
                        ? ((VC0_DEPTH > CRD_DEPTH) ? VC0_DEPTH : CRD_DEPTH)
                        : ((VC1_DEPTH > CRD_DEPTH) ? VC1_DEPTH : CRD_DEPTH);
  localparam int AW   = (MAXD > 2) ? $clog2(MAXD) : 1;
  localparam int IW   = (TOT > 2) ? $clog2(TOT) : 1;

  logic [DW:0]   mem [TOT];
  logic [DW:0]   headWord [3];
  logic [DW:0]   wrWord [3];
  logic [IW-1:0] wrIdx [3];
  logic [2:0]    acc;
  logic [2:0]    pop;
  src_e          srcQ;

  for (genvar q = 0; q < 3; q++) begin : g_reg
    localparam int D = (q == 0) ? VC0_DEPTH : (q == 1) ? VC1_DEPTH : CRD_DEPTH;
    localparam int B = (q == 0) ? 0 : (q == 1) ? VC0_DEPTH : VC0_DEPTH + VC1_DEPTH;

    logic [AW-1:0] rdP;
    logic [AW-1:0] wrP;
    logic [AW:0]   cnt;
    logic          want;

    if (q < 2) begin : g_data
      assign want      = cellValid && (cellVc == 1'(q));
      assign wrWord[q] = {cellLast, cellData};
    end else begin : g_ctl
      assign want      = crdValid;
      assign wrWord[q] = {1'b1, crdData};
    end

    assign qFull[q]    = (cnt == (AW+1)'(D));
    assign acc[q]      = want && !qFull[q];
    assign pop[q]      = pk.send && (pk.src == src_e'(q));
    assign notEmpty[q] = (cnt != '0);
    assign wrIdx[q]    = IW'(B) + IW'(wrP);
    assign headWord[q] = mem[IW'(B) + IW'(rdP)];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rdP <= '0;
        wrP <= '0;
        cnt <= '0;
      end else begin
        if (acc[q]) wrP <= (wrP == AW'(D-1)) ? '0 : wrP + 1'b1;
        if (pop[q]) rdP <= (rdP == AW'(D-1)) ? '0 : rdP + 1'b1;
        case ({acc[q], pop[q]})
          2'b10:   cnt <= cnt + 1'b1;
          2'b01:   cnt <= cnt - 1'b1;
          default: cnt <= cnt;
        endcase
      end
    end

    // R9: a region never holds more than its fixed share
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
      cnt <= (AW+1)'(D));
    // R2: only a region holding a word is popped
    a_r2_pop_nonempty: assert property (@(posedge clk) disable iff (!rstN)
      pop[q] |-> (cnt != '0));
  end

  assign headLast = {headWord[1][DW], headWord[0][DW]};

  always_ff @(posedge clk) begin
    for (int q = 0; q < 3; q++) begin
      if (acc[q]) mem[wrIdx[q]] <= wrWord[q];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkValid <= 1'b0;
      srcQ      <= SRC_VC0;
      linkData  <= '0;
      linkLast  <= 1'b0;
    end else begin
      linkValid <= pk.send;
      if (pk.send) begin
        srcQ <= pk.src;
        case (pk.src)
          SRC_VC0: {linkLast, linkData} <= headWord[0];
          SRC_VC1: {linkLast, linkData} <= headWord[1];
          default: {linkLast, linkData} <= headWord[2];
        endcase
      end
    end
  end

  assign linkSrc = srcQ;

  // R3: at most one region is drained per cycle
  a_r3_single_pick: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pop));
  // R5: inside a packet the link never carries another source
  a_r5_hold_channel: assert property (@(posedge clk) disable iff (!rstN)
    (linkValid && (linkSrc != 2'd2) && !linkLast)
      |=> (!linkValid || (linkSrc == $past(linkSrc))));

endmodule

// File: rtl/oport_arb.sv
module oport_arb
  import oport_pkg::*;
#(
  parameter int DW        = 8,
  parameter int VC0_DEPTH = 4,
  parameter int VC1_DEPTH = 4,
  parameter int CRD_DEPTH = 2,
  parameter int CNT_W     = 4,
  parameter int CNT_INIT  = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cellValid,
  input  logic          cellVc,
  input  logic [DW-1:0] cellData,
  input  logic          cellLast,
  input  logic          crdValid,
  input  logic [DW-1:0] crdData,
  input  logic          retValid,
  input  logic          retVc,
  input  logic          linkReady,
  output logic          linkValid,
  output logic [1:0]    linkSrc,
  output logic [DW-1:0] linkData,
  output logic          linkLast,
  output logic [2:0]    qFull
);

  pick_s      pk;
  logic [2:0] notEmpty;
  logic [1:0] headLast;

  oport_pick #(
    .CNT_W   (CNT_W),
    .CNT_INIT(CNT_INIT)
  ) u_pick (
    .clk      (clk),
    .rstN     (rstN),
    .notEmpty (notEmpty),
    .headLast (headLast),
    .linkReady(linkReady),
    .retValid (retValid),
    .retVc    (retVc),
    .pk       (pk)
  );

  oport_store #(
    .DW       (DW),
    .VC0_DEPTH(VC0_DEPTH),
    .VC1_DEPTH(VC1_DEPTH),
    .CRD_DEPTH(CRD_DEPTH)
  ) u_store (
    .clk      (clk),
    .rstN     (rstN),
    .cellValid(cellValid),
    .cellVc   (cellVc),
    .cellData (cellData),
    .cellLast (cellLast),
    .crdValid (crdValid),
    .crdData  (crdData),
    .pk       (pk),
    .notEmpty (notEmpty),
    .headLast (headLast),
    .qFull    (qFull),
    .linkValid(linkValid),
    .linkSrc  (linkSrc),
    .linkData (linkData),
    .linkLast (linkLast)
  );

endmodule

// File: tb/oport_arb_bench.sv
module oport_arb_bench;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cellValid = 1'b0;
  logic          cellVc = 1'b0;
  logic [DW-1:0] cellData = '0;
  logic          cellLast = 1'b0;
  logic          crdValid = 1'b0;
  logic [DW-1:0] crdData = '0;
  logic          retValid = 1'b0;
  logic          retVc = 1'b0;
  logic          linkReady = 1'b0;
  logic          linkValid;
  logic [1:0]    linkSrc;
  logic [DW-1:0] linkData;
  logic          linkLast;
  logic [2:0]    qFull;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  oport_arb #(
    .DW(DW), .VC0_DEPTH(4), .VC1_DEPTH(4), .CRD_DEPTH(2),
    .CNT_W(4), .CNT_INIT(2)
  ) u_oport_arb (
    .clk(clk), .rstN(rstN),
    .cellValid(cellValid), .cellVc(cellVc), .cellData(cellData), .cellLast(cellLast),
    .crdValid(crdValid), .crdData(crdData),
    .retValid(retValid), .retVc(retVc),
    .linkReady(linkReady),
    .linkValid(linkValid), .linkSrc(linkSrc), .linkData(linkData), .linkLast(linkLast),
    .qFull(qFull)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expectCell(string req, int src, int data, bit last);
    int act;
    int exp;
    act = {linkValid, linkSrc, linkLast, linkData};
    exp = {1'b1, src[1:0], last, data[DW-1:0]};
    check(act == exp, req, act, exp);
  endtask

  task automatic expectIdle(string req);
    check(linkValid == 1'b0, req, linkValid, 0);
  endtask

  task automatic putCell(bit vc, int data, bit last);
    cellValid = 1'b1; cellVc = vc; cellData = data[DW-1:0]; cellLast = last;
    tick();
    cellValid = 1'b0;
  endtask

  task automatic putCrd(int data);
    crdValid = 1'b1; crdData = data[DW-1:0];
    tick();
    crdValid = 1'b0;
  endtask

  task automatic giveBack(bit vc, int n);
    for (int i = 0; i < n; i++) begin
      retValid = 1'b1; retVc = vc;
      tick();
      retValid = 1'b0;
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #80000;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1: idle link and empty regions after reset
    expectIdle("R1 link after reset");
    check(qFull == 3'b000, "R1 qFull after reset", qFull, 0);

    // R2 R8 R10: sweep packet lengths on both channels
    for (int vc = 0; vc < 2; vc++) begin
      for (int len = 1; len <= 4; len++) begin
        linkReady = 1'b0;
        for (int i = 0; i < len; i++) putCell(vc[0], vc*64 + len*8 + i, i == len-1);
        tick();
        expectIdle("R10 link held while not ready");
        linkReady = 1'b1;
        for (int i = 0; i < len; i++) begin
          retValid = 1'b1; retVc = vc[0];   // R8: return alongside each send
          tick();
          retValid = 1'b0;
          expectCell("R2 R8 sweep cell", vc, vc*64 + len*8 + i, i == len-1);
        end
        tick();
        expectIdle("R2 sweep drained");
      end
    end

    // R2: cut-through, write at edge k, on link after edge k+1
    linkReady = 1'b1;
    cellValid = 1'b1; cellVc = 1'b0; cellData = 8'h55; cellLast = 1'b1;
    tick();
    cellValid = 1'b0;
    expectIdle("R2 not yet on link");
    tick();
    expectCell("R2 cut-through", 0, 8'h55, 1'b1);
    giveBack(1'b0, 1);

    // R3 R4: credit message first, then channel 0, then channel 1
    linkReady = 1'b0;
    putCell(1'b1, 8'h31, 1'b1);
    putCell(1'b0, 8'h30, 1'b1);
    putCrd(8'hC7);
    linkReady = 1'b1;
    tick(); expectCell("R3 flow-control message first", 2, 8'hC7, 1'b1);
    tick(); expectCell("R4 channel 0 before channel 1", 0, 8'h30, 1'b1);
    tick(); expectCell("R4 channel 1 last", 1, 8'h31, 1'b1);
    giveBack(1'b0, 1); giveBack(1'b1, 1);

    // R5: lock on channel 1 until its last cell
    linkReady = 1'b0;
    putCell(1'b1, 8'h41, 1'b0);
    putCell(1'b1, 8'h42, 1'b1);
    linkReady = 1'b1;
    cellValid = 1'b1; cellVc = 1'b0; cellData = 8'h40; cellLast = 1'b1;
    crdValid = 1'b1; crdData = 8'hC5;
    tick();
    cellValid = 1'b0; crdValid = 1'b0;
    expectCell("R5 packet start", 1, 8'h41, 1'b0);
    tick(); expectCell("R5 packet kept to its end", 1, 8'h42, 1'b1);
    tick(); expectCell("R5 waiting message after packet", 2, 8'hC5, 1'b1);
    tick(); expectCell("R5 waiting channel 0 after packet", 0, 8'h40, 1'b1);
    giveBack(1'b1, 2); giveBack(1'b0, 1);

    // R6: underrun in the middle of a packet stalls the link
    linkReady = 1'b1;
    putCell(1'b1, 8'h61, 1'b0);
    cellValid = 1'b1; cellVc = 1'b0; cellData = 8'h60; cellLast = 1'b1;
    tick();
    cellValid = 1'b0;
    expectCell("R6 first cell out", 1, 8'h61, 1'b0);
    crdValid = 1'b1; crdData = 8'hC6;
    tick();
    crdValid = 1'b0;
    expectIdle("R6 stall, channel 0 waiting");
    tick();
    expectIdle("R6 stall, message waiting");
    putCell(1'b1, 8'h62, 1'b1);
    expectIdle("R6 stall while rest arrives");
    tick(); expectCell("R6 packet resumes", 1, 8'h62, 1'b1);
    tick(); expectCell("R6 message after packet", 2, 8'hC6, 1'b1);
    tick(); expectCell("R6 channel 0 after packet", 0, 8'h60, 1'b1);
    giveBack(1'b1, 2); giveBack(1'b0, 1);

    // R7: credit exhaustion, channel 1 not blocked
    linkReady = 1'b0;
    for (int i = 0; i < 3; i++) putCell(1'b0, 8'h70 + i, 1'b1);
    putCell(1'b1, 8'h7F, 1'b1);
    linkReady = 1'b1;
    tick(); expectCell("R7 channel 0 credit 2", 0, 8'h70, 1'b1);
    tick(); expectCell("R7 channel 0 credit 1", 0, 8'h71, 1'b1);
    tick(); expectCell("R7 channel 1 passes starved channel 0", 1, 8'h7F, 1'b1);
    tick(); expectIdle("R7 no credit, no send");
    retValid = 1'b1; retVc = 1'b0;
    tick();
    retValid = 1'b0;
    expectIdle("R8 credit arrives, pick follows");
    tick(); expectCell("R8 returned credit used", 0, 8'h72, 1'b1);
    giveBack(1'b0, 2); giveBack(1'b1, 1);

    // R9: static regions, overflow dropped
    linkReady = 1'b0;
    for (int i = 0; i < 5; i++) putCell(1'b0, 8'hA0 + i, 1'b1);
    check(qFull == 3'b001, "R9 channel 0 region full only", qFull, 3'b001);
    for (int i = 0; i < 3; i++) putCrd(8'hC0 + i);
    check(qFull == 3'b101, "R9 message region full", qFull, 3'b101);
    linkReady = 1'b1;
    tick(); expectCell("R9 message 0", 2, 8'hC0, 1'b1);
    tick(); expectCell("R9 message 1", 2, 8'hC1, 1'b1);
    for (int i = 0; i < 4; i++) begin
      retValid = 1'b1; retVc = 1'b0;
      tick();
      retValid = 1'b0;
      expectCell("R9 kept cell", 0, 8'hA0 + i, 1'b1);
    end
    tick(); expectIdle("R9 dropped cell absent");
    check(qFull == 3'b000, "R9 regions drained", qFull, 0);

    finishRun();
  end

endmodule